// File: doc/BRIEF.md
# Word Stream Record Deserializer

This block rebuilds one fixed-size packed record from a run of narrow words that arrive on an AXI4-Stream slave port. The record is B bits wide and the channel is W bits wide, so every record takes a fixed number of beats, N = ceil(B/W). Word 0 carries the lowest W bits of the record. Each following word carries the next W bits. The words sit back to back with no gaps, so a record written by a serializer with the same layout and the same W comes back bit for bit.

The finished record appears on a parallel valid/ready output. A two-bit status travels with it and tells the consumer where TLAST showed up while the record was collected. TLAST never sets the record length. An early TLAST is only reported, and collection goes on until all N beats are in. In the last word, any bits above record bit B-1 are padding and are thrown away.

While a finished record waits on the output and the consumer is not ready, the input stalls. A new beat can be accepted in the same cycle that the waiting record is taken.

Top module: `stream_record_unpacker`

## Requirements
- R1: After reset, the first beat accepted starts a record, and that record appears with m_valid high right after the clock edge that accepts the Nth beat. m_valid stays low after every earlier beat.
- R2: Accepted word j (counted from 0) fills record bits j*W and upward, least significant bit first, with no padding between words.
- R3: Bits of the last word above record position B-1 have no effect on m_rec or m_stat.
- R4: m_stat is 2'b00 when no beat of the record had TLAST set.
- R5: m_stat is 2'b01 when TLAST was set only on the record's final beat.
- R6: m_stat is 2'b10 when TLAST was set on any beat before the final one. This holds whether or not the final beat also had TLAST.
- R7: An early TLAST does not shorten the record. The next record still begins only after N beats in total.
- R8: While m_valid is high and m_ready is low, s_tready is low, and m_rec and m_stat hold their values. A beat offered during that time is not consumed.
- R9: s_tready is high whenever m_valid is low or m_ready is high. A beat can be accepted in the same cycle that the waiting record is taken.
- R10: A synchronous active-high rst clears m_valid and drops any partly collected record. The next accepted beat is word 0.
- R11: m_stat never takes the value 2'b11 while m_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | W | Incoming word |
| s_tvalid | input | 1 | Incoming word is valid |
| s_tlast | input | 1 | TLAST marker of the incoming word |
| s_tready | output | 1 | Block can take a word |
| m_rec | output | B | Reassembled record |
| m_stat | output | 2 | TLAST status: 00 none, 01 final beat only, 10 early |
| m_valid | output | 1 | Record and status are valid |
| m_ready | input | 1 | Consumer takes the record |

## Verification
The beat counter is the only hidden state that decides where a word lands. If it drifts, the error shows up in the very next record at the output: bytes sit in the wrong slice, or the record appears one beat early or late. A stale early-TLAST flag shows up as a wrong status on the next record. A reset that fails to clear the partial record shifts the first record after reset. The bench compares every record against values it computes from the layout rule. It also checks the number of beats before each m_valid, so any such fault appears within one record.

// File: rtl/stream_record_unpacker.sv
module stream_record_unpacker #(
  parameter int W = 8,
  parameter int B = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] s_tdata,
  input  logic         s_tvalid,
  input  logic         s_tlast,
  output logic         s_tready,
  output logic [B-1:0] m_rec,
  output logic [1:0]   m_stat,
  output logic         m_valid,
  input  logic         m_ready
);
  localparam int N  = (B + W - 1) / W;
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0]  beat;
  logic [N*W-1:0] acc;
  logic [N*W-1:0] merged;
  logic           early;

  assign s_tready = ~m_valid | m_ready;

  wire take       = s_tvalid & s_tready;
  wire final_beat = (beat == CW'(N - 1));

  always_comb begin
    merged = acc;
    merged[beat*W +: W] = s_tdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat    <= '0;
      acc     <= '0;
      early   <= 1'b0;
      m_valid <= 1'b0;
      m_rec   <= '0;
      m_stat  <= 2'b00;
    end else begin
      if (m_valid && m_ready)
        m_valid <= 1'b0;
      if (take) begin
        acc[beat*W +: W] <= s_tdata;
        if (final_beat) begin
          beat    <= '0;
          early   <= 1'b0;
          m_valid <= 1'b1;
          m_rec   <= merged[B-1:0];
          m_stat  <= early ? 2'b10 : {1'b0, s_tlast};
        end else begin
          beat  <= beat + 1'b1;
          early <= early | s_tlast;
        end
      end
    end
  end
endmodule

module stream_record_unpacker_chk #(
  parameter int W = 8,
  parameter int B = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         s_tready,
  input logic [B-1:0] m_rec,
  input logic [1:0]   m_stat,
  input logic         m_valid,
  input logic         m_ready,
  input logic [((((B+W-1)/W) > 1) ? $clog2((B+W-1)/W) : 1)-1:0] beat
);
  localparam int N = (B + W - 1) / W;
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_rec) && $stable(m_stat)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_tready);

  // R9
  ready_free_chk: assert property (@(posedge clk) disable iff (rst)
    (!m_valid || m_ready) |-> s_tready);

  // R11
  stat_code_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_stat != 2'b11));

  // R1
  beat_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(beat) < N);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst_q |-> (!m_valid && beat == '0));
endmodule

bind stream_record_unpacker stream_record_unpacker_chk #(.W(W), .B(B)) chk_i (
  .clk(clk), .rst(rst), .s_tready(s_tready), .m_rec(m_rec), .m_stat(m_stat),
  .m_valid(m_valid), .m_ready(m_ready), .beat(beat)
);

// File: tb/stream_record_unpacker_tb.sv
module stream_record_unpacker_tb_top;
  localparam int W = 8;
  localparam int B = 20;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, m_ready = 1'b0;
  logic s_tready, m_valid;
  logic [B-1:0] m_rec;
  logic [1:0] m_stat;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_record_unpacker #(.W(W), .B(B)) dut_i (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tready(s_tready), .m_rec(m_rec), .m_stat(m_stat), .m_valid(m_valid), .m_ready(m_ready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat_in(input logic [W-1:0] d, input logic l);
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = d; s_tlast = l;
    #1;
    while (!s_tready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  function automatic logic [W-1:0] word_of(input logic [B-1:0] r, input int j, input logic [3:0] pad);
    logic [23:0] ext = {pad, r};
    return ext[j*W +: W];
  endfunction

  // pattern: 0 none, 1 final only, 2 early on beat 0, 3 early on beat 1 plus final
  task automatic send_rec(input logic [B-1:0] r, input int pat, input logic [3:0] pad);
    for (int j = 0; j < 3; j++) begin
      logic l;
      l = (pat == 1 && j == 2) || (pat == 2 && j == 0) || (pat == 3 && (j == 1 || j == 2));
      beat_in(word_of(r, j, pad), l);
      @(negedge clk);
      if (j < 2) chk(m_valid == 1'b0, (pat >= 2) ? "R7 no early record" : "R1 no early valid", m_valid, 0);
      else       chk(m_valid == 1'b1, "R1 valid after third beat", m_valid, 1);
    end
  endtask

  task automatic take_rec(input logic [B-1:0] r, input logic [1:0] st, input int stall);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(s_tready == 1'b0, "R8 stall tready", s_tready, 0);
      chk(m_rec == r, "R8 stall hold", m_rec, r);
    end
    @(negedge clk);
    chk(m_rec == r, "R2 R3 record", m_rec, r);
    case (st)
      2'b00: chk(m_stat == st, "R4 status none", m_stat, st);
      2'b01: chk(m_stat == st, "R5 status final", m_stat, st);
      default: chk(m_stat == st, "R6 status early", m_stat, st);
    endcase
    chk(m_stat != 2'b11, "R11 status code", m_stat, 0);
    m_ready = 1'b1;
    @(posedge clk); #1;
    m_ready = 1'b0;
    @(negedge clk);
    chk(m_valid == 1'b0, "R9 record taken", m_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [B-1:0] ra, rb;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(m_valid == 1'b0, "R10 reset valid", m_valid, 0);
    chk(s_tready == 1'b1, "R9 idle ready", s_tready, 1);

    for (int i = 0; i < 96; i++) begin
      logic [B-1:0] r;
      logic [1:0] st;
      r  = B'(i * 32'h3A5C7 + 32'h1F);
      st = (i % 4 == 0) ? 2'b00 : (i % 4 == 1) ? 2'b01 : 2'b10;
      send_rec(r, i % 4, 4'(i));
      take_rec(r, st, i % 3);
    end
    send_rec('1, 0, 4'h0);   take_rec('1, 2'b00, 0);
    send_rec('0, 1, 4'hF);   take_rec('0, 2'b01, 1);

    ra = 20'hC3A51; rb = 20'h0F7E2;
    send_rec(ra, 0, 4'h5);
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = word_of(rb, 0, 4'h0); s_tlast = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(s_tready == 1'b0, "R8 pending beat blocked", s_tready, 0);
      chk(m_rec == ra, "R8 pending beat no effect", m_rec, ra);
    end
    m_ready = 1'b1;
    #1;
    chk(s_tready == 1'b1, "R9 ready with consumer", s_tready, 1);
    @(posedge clk); #1;
    s_tvalid = 1'b0; m_ready = 1'b0;
    beat_in(word_of(rb, 1, 4'h0), 1'b0);
    @(negedge clk);
    chk(m_valid == 1'b0, "R9 overlap beat count", m_valid, 0);
    beat_in(word_of(rb, 2, 4'h9), 1'b1);
    take_rec(rb, 2'b01, 0);

    beat_in(8'hAA, 1'b1);
    beat_in(8'h55, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(m_valid == 1'b0, "R10 reset mid record", m_valid, 0);
    send_rec(20'h6B1D4, 0, 4'h3);
    take_rec(20'h6B1D4, 2'b00, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule